// File: doc/BRIEF.md
# ECC Chunk Status Accumulator

After a page has passed through the error-correction decoder, each data chunk of the page has one status byte. This block reads those bytes and keeps two running totals. The first total is the number of bit errors that were corrected. The second is the number of chunks that could not be corrected. Two status values are reserved: one marks an erased chunk and one marks an uncorrectable chunk. Every other value is a count of corrected bits.

The status bytes can come from two places, picked by a source select input. In stream mode they arrive as a byte stream qualified by a valid signal. In memory mode the block scans a small auxiliary byte memory that it holds itself. That memory is filled through a write port, and the scan starts at the first 4-byte-aligned offset after the metadata bytes. The number of chunks in the page comes from two size exponents, one for the page and one for the chunk. Once that many bytes have been counted, the block raises a one-cycle done pulse and holds the totals. The totals stay held until a clear, or a new memory scan, starts the next page.

Top module: `ecc_chunk_status_acc`

## Requirements
- R1: A status byte of 0x00 (clean chunk) leaves both totals unchanged.
- R2: A status byte of 0xFF (erased chunk) leaves both totals unchanged.
- R3: A status byte of 0xFE (uncorrectable chunk) raises the failed-chunk total by one and leaves the corrected total unchanged.
- R4: Any status byte other than 0x00, 0xFF and 0xFE is added to the corrected-bit total.
- R5: The chunk count is 2^(page_shift - chunk_shift). It is clamped to 1 when chunk_shift >= page_shift, and clamped to MAX_CHUNKS when the difference exceeds log2(MAX_CHUNKS). Once that many bytes have been taken, later bytes are ignored until the next clear or scan start.
- R6: done is high for exactly one cycle. It is the cycle in which the totals first include the last chunk of the page.
- R7: A scan_start pulse in memory mode reads the chunk statuses, in increasing address order, from auxiliary offsets BASE, BASE+1, and so on. BASE is META_BYTES (default 10) rounded up to a multiple of 4, which is 12 by default. For a scan started at clock edge E0, done is visible in the cycle after edge E0+N+1, where N is the chunk count.
- R8: clr, and scan_start as well, zeroes both totals and the chunk counter at the next edge. A clr in the same cycle as a valid byte wins, and that byte is dropped.
- R9: The corrected-bit total saturates at 2^CORR_W-1 and does not wrap.
- R10: The failed-chunk total saturates at 2^FAIL_W-1 and does not wrap.
- R11: While src_sel is 1 (memory mode), bytes on the stream input have no effect.
- R12: After reset both totals are zero and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clears totals and chunk counter |
| src_sel | input | 1 | 0 = byte stream, 1 = auxiliary memory |
| page_shift | input | SH_W (4) | log2 of page data size in bytes |
| chunk_shift | input | SH_W (4) | log2 of chunk data size in bytes |
| s_valid | input | 1 | Stream byte valid |
| s_status | input | 8 | Stream status byte |
| wr_en | input | 1 | Auxiliary memory write enable |
| wr_addr | input | AW (6) | Auxiliary memory write address |
| wr_data | input | 8 | Auxiliary memory write data |
| scan_start | input | 1 | Clears totals; in memory mode starts a scan |
| corr_total | output | CORR_W (10) | Saturating corrected-bit total |
| fail_total | output | FAIL_W (3) | Saturating failed-chunk total |
| done | output | 1 | One-cycle pulse when the last chunk is counted |

## Verification
The embedded properties check, on every cycle, the following rules:
- clean and erased codes leave the totals unchanged;
- an uncorrectable code steps the failed total by exactly one;
- both totals hold at their ceilings instead of wrapping;
- done never lasts longer than one cycle;
- memory reads never go past the chunk window.

Some behaviour can only be shown by the bench scenarios. These cover:
- how the chunk count is derived from the two exponents, including both clamps;
- the exact scan latency and the auxiliary offset used;
- that bytes after completion, and stream bytes in memory mode, are ignored;
- that clear takes priority over a byte in the same cycle.

// File: rtl/ecc_acc_pkg.sv
package ecc_acc_pkg;
  localparam logic [7:0] ST_CLEAN  = 8'h00;
  localparam logic [7:0] ST_ERASED = 8'hFF;
  localparam logic [7:0] ST_UNCORR = 8'hFE;

  typedef struct packed {
    logic       fail;
    logic [7:0] bits;
  } chunk_verdict_t;
endpackage

// File: rtl/ecc_stat_classify.sv
module ecc_stat_classify
  import ecc_acc_pkg::*;
(
  input  logic [7:0]     code,
  output chunk_verdict_t verdict
);
  always_comb begin
    verdict.fail = 1'b0;
    verdict.bits = 8'd0;
    if (code == ST_UNCORR) begin
      verdict.fail = 1'b1;
    end else if (code != ST_CLEAN && code != ST_ERASED) begin
      verdict.bits = code;
    end
  end
endmodule

// File: rtl/ecc_stat_ram.sv
module ecc_stat_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ecc_stat_sequencer.sv
module ecc_stat_sequencer #(
  parameter int MAX_CHUNKS = 16,
  parameter int CW         = $clog2(MAX_CHUNKS + 1),
  parameter int AW         = 6,
  parameter int BASE       = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] chunks,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          out_v
);
  logic [CW-1:0] idx;
  logic          active;

  assign rd_en   = active;
  assign rd_addr = AW'(BASE) + AW'(idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
      out_v  <= 1'b0;
    end else begin
      out_v <= rd_en;
      if (start) begin
        active <= 1'b1;
        idx    <= '0;
      end else if (active) begin
        idx <= idx + 1'b1;
        if (idx == chunks - 1'b1) active <= 1'b0;
      end
    end
  end

  assert_read_in_window_R7: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (idx < chunks && rd_addr >= AW'(BASE)));
endmodule

// File: rtl/ecc_stat_acc.sv
module ecc_stat_acc
  import ecc_acc_pkg::*;
#(
  parameter int CORR_W = 10,
  parameter int FAIL_W = 3,
  parameter int CW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              byte_v,
  input  logic [7:0]        code,
  input  logic [CW-1:0]     chunks,
  output logic [CORR_W-1:0] corr_total,
  output logic [FAIL_W-1:0] fail_total,
  output logic              done
);
  localparam logic [CORR_W-1:0] CORR_MAX = {CORR_W{1'b1}};
  localparam logic [FAIL_W-1:0] FAIL_MAX = {FAIL_W{1'b1}};

  chunk_verdict_t    verdict;
  logic [CW-1:0]     cnt;
  logic              complete;
  logic              accept;
  logic              last;
  logic [CORR_W:0]   corr_sum;

  ecc_stat_classify u_classify (.code(code), .verdict(verdict));

  assign accept   = byte_v && !complete && !clr;
  assign last     = accept && ((cnt + 1'b1) == chunks);
  assign corr_sum = {1'b0, corr_total} + (CORR_W + 1)'(verdict.bits);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      corr_total <= '0;
      fail_total <= '0;
      cnt        <= '0;
      complete   <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        cnt <= cnt + 1'b1;
        if (last) complete <= 1'b1;
        corr_total <= corr_sum[CORR_W] ? CORR_MAX : corr_sum[CORR_W-1:0];
        if (verdict.fail && fail_total != FAIL_MAX)
          fail_total <= fail_total + 1'b1;
      end
    end
  end

  assert_clean_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (accept && code == ST_CLEAN) |=> ($stable(corr_total) && $stable(fail_total)));
  assert_erased_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && code == ST_ERASED) |=> ($stable(corr_total) && $stable(fail_total)));
  assert_uncorr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && code == ST_UNCORR && fail_total != FAIL_MAX)
      |=> (fail_total == $past(fail_total) + 1'b1 && $stable(corr_total)));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_corr_ceiling_R9: assert property (@(posedge clk) disable iff (rst)
    (!clr && corr_total == CORR_MAX) |=> corr_total == CORR_MAX);
  assert_fail_ceiling_R10: assert property (@(posedge clk) disable iff (rst)
    (!clr && fail_total == FAIL_MAX) |=> fail_total == FAIL_MAX);
endmodule

// File: rtl/ecc_chunk_status_acc.sv
module ecc_chunk_status_acc #(
  parameter int MAX_CHUNKS = 16,
  parameter int SH_W       = 4,
  parameter int CORR_W     = 10,
  parameter int FAIL_W     = 3,
  parameter int META_BYTES = 10,
  parameter int AUX_DEPTH  = 64,
  parameter int AW         = $clog2(AUX_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              src_sel,
  input  logic [SH_W-1:0]   page_shift,
  input  logic [SH_W-1:0]   chunk_shift,
  input  logic              s_valid,
  input  logic [7:0]        s_status,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              scan_start,
  output logic [CORR_W-1:0] corr_total,
  output logic [FAIL_W-1:0] fail_total,
  output logic              done
);
  localparam int CW      = $clog2(MAX_CHUNKS + 1);
  localparam int LOG_MAX = $clog2(MAX_CHUNKS);
  localparam int BASE    = ((META_BYTES + 3) / 4) * 4;

  logic [SH_W:0]  diff;
  logic [CW-1:0]  chunks;
  logic           rd_en;
  logic [AW-1:0]  rd_addr;
  logic [7:0]     rd_data;
  logic           mem_v;
  logic           acc_v;
  logic [7:0]     acc_code;

  always_comb begin
    diff = (page_shift > chunk_shift) ? ({1'b0, page_shift} - {1'b0, chunk_shift}) : '0;
    if (diff > (SH_W + 1)'(LOG_MAX)) chunks = CW'(MAX_CHUNKS);
    else                             chunks = CW'(1) << diff;
  end

  ecc_stat_ram #(.DEPTH(AUX_DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .re(rd_en), .raddr(rd_addr), .rdata(rd_data)
  );

  ecc_stat_sequencer #(.MAX_CHUNKS(MAX_CHUNKS), .CW(CW), .AW(AW), .BASE(BASE)) u_seq (
    .clk(clk), .rst(rst), .start(scan_start && src_sel), .chunks(chunks),
    .rd_en(rd_en), .rd_addr(rd_addr), .out_v(mem_v)
  );

  assign acc_v    = src_sel ? mem_v   : s_valid;
  assign acc_code = src_sel ? rd_data : s_status;

  ecc_stat_acc #(.CORR_W(CORR_W), .FAIL_W(FAIL_W), .CW(CW)) u_acc (
    .clk(clk), .rst(rst), .clr(clr || scan_start), .byte_v(acc_v),
    .code(acc_code), .chunks(chunks),
    .corr_total(corr_total), .fail_total(fail_total), .done(done)
  );
endmodule

// File: tb/ecc_chunk_status_acc_bench.sv
module ecc_chunk_status_acc_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, clr, src_sel, s_valid, wr_en, scan_start;
  logic [3:0] page_shift, chunk_shift;
  logic [7:0] s_status, wr_data;
  logic [5:0] wr_addr;
  logic [9:0] corr_total;
  logic [2:0] fail_total;
  logic       done;

  int checks = 0;
  int errors = 0;
  logic seen_done;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ecc_chunk_status_acc u_ecc_chunk_status_acc (
    .clk(clk), .rst(rst), .clr(clr), .src_sel(src_sel),
    .page_shift(page_shift), .chunk_shift(chunk_shift),
    .s_valid(s_valid), .s_status(s_status),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .scan_start(scan_start),
    .corr_total(corr_total), .fail_total(fail_total), .done(done)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_totals(input string req, input int corr, input int fail);
    check(corr_total == 10'(corr), req, int'(corr_total), corr);
    check(fail_total == 3'(fail), req, int'(fail_total), fail);
  endtask

  // called at a negedge; returns at the next negedge with done captured
  task automatic send_byte(input logic [7:0] b);
    s_valid  = 1'b1;
    s_status = b;
    @(negedge clk);
    s_valid   = 1'b0;
    seen_done = done;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic t_reset();
    expect_totals("R12", 0, 0);
    check(done == 1'b0, "R12", int'(done), 0);
  endtask

  task automatic t_codes();
    page_shift = 4'd11; chunk_shift = 4'd9;  // 4 chunks
    do_clear();
    send_byte(8'h00); expect_totals("R1", 0, 0); check(!seen_done, "R6", int'(seen_done), 0);
    send_byte(8'hFF); expect_totals("R2", 0, 0); check(!seen_done, "R6", int'(seen_done), 0);
    send_byte(8'hFE); expect_totals("R3", 0, 1); check(!seen_done, "R6", int'(seen_done), 0);
    send_byte(8'h05); expect_totals("R4", 5, 1); check(seen_done, "R6", int'(seen_done), 1);
    @(negedge clk);
    check(done == 1'b0, "R6", int'(done), 0);
    send_byte(8'h07);
    expect_totals("R5", 5, 1);
    check(!seen_done, "R5", int'(seen_done), 0);
  endtask

  task automatic t_count_clamp();
    page_shift = 4'd9; chunk_shift = 4'd11;  // clamps to 1 chunk
    do_clear();
    send_byte(8'h03);
    check(seen_done, "R5", int'(seen_done), 1);
    expect_totals("R5", 3, 0);
    page_shift = 4'd15; chunk_shift = 4'd9;  // diff 6 clamps to 16
    do_clear();
    for (int i = 0; i < 16; i++) begin
      send_byte(8'h01);
      check(seen_done == (i == 15), "R5", int'(seen_done), int'(i == 15));
    end
    expect_totals("R5", 16, 0);
  endtask

  task automatic t_clear_priority();
    page_shift = 4'd11; chunk_shift = 4'd9;
    do_clear();
    send_byte(8'h04);
    clr = 1'b1; s_valid = 1'b1; s_status = 8'h09;
    @(negedge clk);
    clr = 1'b0; s_valid = 1'b0;
    expect_totals("R8", 0, 0);
    send_byte(8'h02);
    expect_totals("R8", 2, 0);
  endtask

  task automatic t_saturate();
    page_shift = 4'd13; chunk_shift = 4'd9;  // 16 chunks
    do_clear();
    for (int i = 0; i < 16; i++) send_byte(8'hFD);
    expect_totals("R9", 1023, 0);
    do_clear();
    for (int i = 0; i < 16; i++) send_byte(8'hFE);
    expect_totals("R10", 0, 7);
  endtask

  task automatic write_aux(input int a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_memory_scan();
    int cyc;
    for (int a = 0; a < 12; a++) write_aux(a, 8'h33);
    write_aux(12, 8'h02); write_aux(13, 8'hFE);
    write_aux(14, 8'h00); write_aux(15, 8'h04);
    write_aux(16, 8'h11);
    page_shift = 4'd11; chunk_shift = 4'd9;  // 4 chunks
    src_sel = 1'b1;
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
    cyc = 1;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == 6, "R7", cyc, 6);
    expect_totals("R7", 6, 1);
    @(negedge clk);
    check(done == 1'b0, "R6", int'(done), 0);
    expect_totals("R7", 6, 1);
  endtask

  task automatic t_stream_ignored();
    src_sel = 1'b1;
    do_clear();
    for (int i = 0; i < 4; i++) begin
      send_byte(8'h05);
      check(!seen_done, "R11", int'(seen_done), 0);
    end
    expect_totals("R11", 0, 0);
    src_sel = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; clr = 1'b0; src_sel = 1'b0; s_valid = 1'b0; s_status = 8'h00;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; scan_start = 1'b0;
    page_shift = 4'd11; chunk_shift = 4'd9; seen_done = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_codes();
    t_count_clamp();
    t_clear_priority();
    t_saturate();
    t_memory_scan();
    t_stream_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule